// File: doc/BRIEF.md
# Down-Spread Modulation Profile Generator

This block steers a fractional-N clock synthesizer so that its output frequency sweeps in a triangle. The sweep stays at or below the nominal frequency. The block runs on the reference clock. On every reference cycle it produces one signed offset word. The word gives the requested frequency shift in hundredths of a percent, so -300 means three percent below nominal. The synthesizer loop takes this word and adds it to its fractional divide value.

The depth of the sweep comes from two settings. A three-valued spread select chooses low, middle or high. A sub-band index places the reference frequency in one of four slices of its range. A band bit chooses the lower or the upper input band, and the band fixes the sweep period at 256 or 512 reference cycles. The block samples these settings only at the top of each sweep. A one-cycle strobe marks the start of each period. An enable flag tells the clock tree to keep the unmodulated reference copy running while the block is active. An active-low power-down parks everything at nominal frequency, and the block restarts from the top of the profile when power-down is released.

Top module: `ssc_profile_gen`

## Requirements
- R1: `offset_o` is a two's-complement value in hundredths of a percent and is never greater than zero.
- R2: Let n be the phase of the cycle that produced the output, counted from 0 at the period start, P the period length and D the latched depth. Let k = 2n when n < P/2 and k = 2P - 2n otherwise. The output is then -floor(D*k/P): 0 at the period start and -D at mid-period.
- R3: The period is 256 cycles when `band_hi` is 0 and 512 cycles when it is 1. `period_start_o` is high for exactly the first output of each period, and `offset_o` is 0 in that cycle.
- R4: With `spread_sel` = 2'b10 (high), the depth for `sub_band` 0, 1, 2 and 3 is 300, 270, 250 and 230.
- R5: With `spread_sel` = 2'b00 (low), the depth for `sub_band` 0, 1, 2 and 3 is 220, 190, 180 and 170.
- R6: With `spread_sel` = 2'b01 (middle), and also with the undriven code 2'b11, the depth for `sub_band` 0, 1, 2 and 3 is 70, 60, 60 and 50.
- R7: `spread_sel`, `band_hi` and `sub_band` are sampled only in the cycle that starts a period. A change in the middle of a period changes neither the depth nor the period length until the next period start.
- R8: One clock edge after `pd_n` is sampled low, `offset_o` is 0, `period_start_o` is 0 and `ref_en_o` is 0.
- R9: One edge after `pd_n` is sampled high again, the output shows a period start (strobe high, offset 0), and a full period follows.
- R10: `ref_en_o` is 1 one edge after any cycle in which `pd_n` is high and reset is released.
- R11: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Active-low power-down |
| spread_sel | input | 2 | Spread select: 00 low, 01 middle, 10 high, 11 middle |
| band_hi | input | 1 | Input band: 0 gives a 256-cycle period, 1 gives a 512-cycle period |
| sub_band | input | 2 | Slice of the band, ascending in frequency |
| offset_o | output | 10 | Signed frequency offset in hundredths of a percent |
| period_start_o | output | 1 | High for the first output of each period |
| ref_en_o | output | 1 | Unmodulated reference output enable |

## Verification
The bench exercises the following cases and the failure each one reveals:
- **Settings changed mid-sweep.** The select, band and sub-band change halfway through a period. A design that samples them live would show a jump in the offset, or a period that is neither 256 nor 512 cycles long.
- **Power-down in mid-sweep.** Power-down is raised partway through a sweep and later released. A design that resumes the old phase, or keeps the reference enable high during power-down, fails on the cycles right after the change.
- **Rounding near the trough.** Every cycle of the sweep is compared against a floor computation. A design that rounds the other way, or places its midpoint wrongly, is off by one count near the trough.
- **Undriven select code.** A design that mishandles the undriven select code picks a row other than middle.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

    typedef enum logic [1:0] {
        SEL_LOW  = 2'b00,
        SEL_MID  = 2'b01,
        SEL_HIGH = 2'b10,
        SEL_OPEN = 2'b11
    } spread_sel_e;

    localparam int NUM_SUB = 4;

endpackage

// File: rtl/ssc_depth_lut.sv
module ssc_depth_lut #(
    parameter int DEPTH_W = 9
) (
    input  logic [1:0]         sel,
    input  logic [1:0]         sub,
    output logic [DEPTH_W-1:0] depth
);
    import ssc_pkg::*;

    // Depths in hundredths of a percent, one row per select level.
    always_comb begin
        depth = '0;
        unique case (spread_sel_e'(sel))
            SEL_HIGH: begin
                unique case (sub)
                    2'd0:    depth = DEPTH_W'(300);
                    2'd1:    depth = DEPTH_W'(270);
                    2'd2:    depth = DEPTH_W'(250);
                    default: depth = DEPTH_W'(230);
                endcase
            end
            SEL_LOW: begin
                unique case (sub)
                    2'd0:    depth = DEPTH_W'(220);
                    2'd1:    depth = DEPTH_W'(190);
                    2'd2:    depth = DEPTH_W'(180);
                    default: depth = DEPTH_W'(170);
                endcase
            end
            default: begin
                // middle, and the floating (undriven) code
                unique case (sub)
                    2'd0:    depth = DEPTH_W'(70);
                    2'd1:    depth = DEPTH_W'(60);
                    2'd2:    depth = DEPTH_W'(60);
                    default: depth = DEPTH_W'(50);
                endcase
            end
        endcase
    end

endmodule

// File: rtl/ssc_tri_shaper.sv
module ssc_tri_shaper #(
    parameter int LO_LOG2 = 8,
    parameter int DEPTH_W = 9,
    parameter int OFS_W   = 10
) (
    input  logic [LO_LOG2:0]          phase,
    input  logic [DEPTH_W-1:0]        depth,
    input  logic                      band_hi,
    output logic signed [OFS_W-1:0]   offset
);
    localparam int PH_W   = LO_LOG2 + 1;
    localparam int KW     = PH_W + 2;
    localparam int PROD_W = DEPTH_W + KW;

    logic [KW-1:0]     twice_phase;
    logic [KW-1:0]     period2;
    logic [KW-1:0]     k;
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] scaled;
    logic [OFS_W-1:0]  mag;

    always_comb begin
        twice_phase = {1'b0, phase, 1'b0};
        period2     = band_hi ? (KW'(1) << (LO_LOG2 + 2)) : (KW'(1) << (LO_LOG2 + 1));
        // distance from the top of the triangle, scaled by two
        if (twice_phase < (period2 >> 1))
            k = twice_phase;
        else
            k = period2 - twice_phase;
        prod   = PROD_W'(depth) * PROD_W'(k);
        // division by the period is a shift; truncation rounds toward zero
        scaled = band_hi ? (prod >> (LO_LOG2 + 1)) : (prod >> LO_LOG2);
        mag    = scaled[OFS_W-1:0];
        offset = $signed(OFS_W'(0) - mag);
    end

endmodule

// File: rtl/ssc_profile_gen.sv
module ssc_profile_gen #(
    parameter int LO_LOG2 = 8,
    parameter int DEPTH_W = 9,
    parameter int OFS_W   = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     pd_n,
    input  logic [1:0]               spread_sel,
    input  logic                     band_hi,
    input  logic [1:0]               sub_band,
    output logic signed [OFS_W-1:0]  offset_o,
    output logic                     period_start_o,
    output logic                     ref_en_o
);
    localparam int PHASE_W = LO_LOG2 + 1;
    localparam logic [PHASE_W-1:0] LAST_LO = PHASE_W'((1 << LO_LOG2) - 1);
    localparam logic [PHASE_W-1:0] LAST_HI = '1;

    typedef struct packed {
        logic [PHASE_W-1:0]       phase;
        logic [DEPTH_W-1:0]       depth;
        logic                     band_hi;
        logic signed [OFS_W-1:0]  offset;
        logic                     strobe;
        logic                     ref_en;
    } state_t;

    state_t s_d, s_q;

    logic                    at_top;
    logic [DEPTH_W-1:0]      lut_depth;
    logic [DEPTH_W-1:0]      depth_use;
    logic                    band_use;
    logic                    at_last;
    logic signed [OFS_W-1:0] shaped;

    ssc_depth_lut #(.DEPTH_W(DEPTH_W)) i_lut (
        .sel   (spread_sel),
        .sub   (sub_band),
        .depth (lut_depth)
    );

    ssc_tri_shaper #(
        .LO_LOG2 (LO_LOG2),
        .DEPTH_W (DEPTH_W),
        .OFS_W   (OFS_W)
    ) i_shaper (
        .phase   (s_q.phase),
        .depth   (depth_use),
        .band_hi (band_use),
        .offset  (shaped)
    );

    always_comb begin
        at_top    = (s_q.phase == '0);
        depth_use = at_top ? lut_depth : s_q.depth;
        band_use  = at_top ? band_hi   : s_q.band_hi;
        at_last   = band_use ? (s_q.phase == LAST_HI) : (s_q.phase == LAST_LO);

        s_d = s_q;
        if (!pd_n) begin
            s_d.phase  = '0;
            s_d.offset = '0;
            s_d.strobe = 1'b0;
            s_d.ref_en = 1'b0;
        end else begin
            s_d.depth   = depth_use;
            s_d.band_hi = band_use;
            s_d.offset  = shaped;
            s_d.strobe  = at_top;
            s_d.ref_en  = 1'b1;
            s_d.phase   = at_last ? '0 : s_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign offset_o       = s_q.offset;
    assign period_start_o = s_q.strobe;
    assign ref_en_o       = s_q.ref_en;

    a_r1_not_above_nominal: assert property (@(posedge clk) disable iff (!rst_n)
        offset_o <= 0);

    a_r2_within_depth: assert property (@(posedge clk) disable iff (!rst_n)
        $signed({1'b0, offset_o[OFS_W-1] ? -offset_o : offset_o}) <= $signed({1'b0, s_q.depth}));

    a_r3_strobe_at_top: assert property (@(posedge clk) disable iff (!rst_n)
        period_start_o |-> offset_o == 0);

    a_r3_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        period_start_o |=> !period_start_o);

    a_r7_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase != '0) |=> ($stable(s_q.depth) && $stable(s_q.band_hi)));

    a_r8_pd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_n |=> (offset_o == 0 && !period_start_o && !ref_en_o));

    a_r9_restart_top: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_n && !ref_en_o) |=> period_start_o);

    a_r10_ref_en_run: assert property (@(posedge clk) disable iff (!rst_n)
        pd_n |=> ref_en_o);

endmodule

// File: tb/test_ssc_profile_gen.sv
`timescale 1ns/1ps
module test_ssc_profile_gen;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              pd_n = 1'b1;
    logic [1:0]        spread_sel = 2'b01;
    logic              band_hi = 1'b0;
    logic [1:0]        sub_band = 2'b00;
    logic signed [9:0] offset_o;
    logic              period_start_o;
    logic              ref_en_o;

    always #4 clk = ~clk;

    ssc_profile_gen i_ssc_profile_gen (
        .clk            (clk),
        .rst_n          (rst_n),
        .pd_n           (pd_n),
        .spread_sel     (spread_sel),
        .band_hi        (band_hi),
        .sub_band       (sub_band),
        .offset_o       (offset_o),
        .period_start_o (period_start_o),
        .ref_en_o       (ref_en_o)
    );

    typedef struct {
        int    ofs;
        bit    stb;
        bit    ren;
        string tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done   = 0;

    int   m_phase = 0;
    int   m_depth = 0;
    bit   m_hi    = 0;

    function automatic int depth_of(input logic [1:0] sel, input logic [1:0] sb);
        int hi_row[4]  = '{300, 270, 250, 230};
        int lo_row[4]  = '{220, 190, 180, 170};
        int mid_row[4] = '{70, 60, 60, 50};
        if (sel == 2'b10) return hi_row[sb];
        if (sel == 2'b00) return lo_row[sb];
        return mid_row[sb];
    endfunction

    task automatic drive(input bit rst, input bit pd, input logic [1:0] sel,
                         input bit hi, input logic [1:0] sb, input string tag);
        exp_t e;
        int   p;
        int   k;
        @(posedge clk);
        #1;
        rst_n = rst; pd_n = pd; spread_sel = sel; band_hi = hi; sub_band = sb;
        e.tag = tag;
        if (!rst || !pd) begin
            e.ofs = 0; e.stb = 0; e.ren = 0;
            m_phase = 0;
        end else begin
            if (m_phase == 0) begin
                m_depth = depth_of(sel, sb);
                m_hi    = hi;
            end
            p = m_hi ? 512 : 256;
            k = (m_phase < p / 2) ? 2 * m_phase : 2 * p - 2 * m_phase;
            e.ofs = -((m_depth * k) / p);
            e.stb = (m_phase == 0);
            e.ren = 1;
            m_phase = (m_phase == p - 1) ? 0 : m_phase + 1;
        end
        q.push_back(e);
    endtask

    // monitor: item pushed in the previous cycle is now visible at the outputs
    initial begin
        forever begin
            @(posedge clk);
            #3;
            if (q.size() >= 2) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (int'(offset_o) != e.ofs || period_start_o != e.stb || ref_en_o != e.ren) begin
                    errors++;
                    $display("FAIL %s: actual ofs=%0d stb=%0b ren=%0b expected ofs=%0d stb=%0b ren=%0b",
                             e.tag, offset_o, period_start_o, ref_en_o, e.ofs, e.stb, e.ren);
                end
            end
        end
    end

    initial begin
        #1600000;
        if (!done) begin
            errors++;
            $display("FAIL R3 watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R11: reset state
        for (int i = 0; i < 5; i++) drive(0, 1, 2'b10, 0, 2'd0, "R11");
        // R4 high row, R2 shape, R3 256-cycle period, R10 enable, R1 sign
        for (int i = 0; i < 512; i++) drive(1, 1, 2'b10, 0, 2'd0, "R4 R2 R3 R10 R1");
        for (int i = 0; i < 512; i++) drive(1, 1, 2'b10, 1, 2'd3, "R4 R3 512");
        // R5 low row
        for (int i = 0; i < 512; i++) drive(1, 1, 2'b00, 1, 2'd1, "R5");
        // R6 middle row and undriven code
        for (int i = 0; i < 256; i++) drive(1, 1, 2'b01, 0, 2'd2, "R6");
        for (int i = 0; i < 256; i++) drive(1, 1, 2'b11, 0, 2'd0, "R6 open");
        // R7 settings changed mid-period
        for (int i = 0; i < 100; i++) drive(1, 1, 2'b10, 0, 2'd0, "R7 before");
        for (int i = 0; i < 156; i++) drive(1, 1, 2'b00, 1, 2'd3, "R7 held");
        for (int i = 0; i < 512; i++) drive(1, 1, 2'b00, 1, 2'd3, "R7 applied");
        // R8 power-down in mid-sweep, R9 restart
        for (int i = 0; i < 60; i++)  drive(1, 1, 2'b10, 0, 2'd1, "R8 run");
        for (int i = 0; i < 10; i++)  drive(1, 0, 2'b10, 0, 2'd1, "R8");
        for (int i = 0; i < 300; i++) drive(1, 1, 2'b10, 0, 2'd1, "R9");
        drive(1, 1, 2'b10, 0, 2'd1, "R9 flush");
        @(posedge clk);
        #5;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule